// File: doc/BRIEF.md
# Serial Shift Unit Clock Selector

This block is an 8-bit serial shift register paired with a 4-bit transfer counter. Each has its own clock routing, chosen by a control word. The register can advance on a software strobe, a timer overflow pulse, or one chosen edge of an external serial clock. The counter can follow the same strobe or timer pulse, can count both edges of the external clock, or can count software toggle writes. The external clock is brought into the system clock domain by a two-flop synchroniser, and its edges are detected there.

Data enters at the LSB and leaves from the MSB. The serial output is transparent in the strobe and timer modes. In the external modes it is held in a latch that updates on the clock edge opposite the sampling edge. A toggle write inverts a clock-pin output register in every mode, so a master can generate its own serial clock. When the counter wraps it raises a sticky overflow flag. Both the register and the counter can be loaded in parallel.

Top module: `ssu_clk_sel`

## Requirements
- R1: With select field 00 and no strobe write, the shift register and the counter never change; timer pulses and external clock edges are ignored.
- R2: A control write with bits [3:2]=00 and bit 1 set shifts the register once and increments the counter once at that clock edge. The serial output shows the new MSB right after that edge. The bit shifted in is the serial input as it was one cycle before the write.
- R3: With select field 01, each timer overflow pulse shifts the register and increments the counter. A strobe bit written in this mode has no effect.
- R4: With select 10 the register shifts on the rising edge of the synchronised external clock; with select 11 it shifts on the falling edge. A level change on the external clock input acts at the third system clock edge after it.
- R5: In the external modes with the select bit (control bit 1) clear, the counter increments on both edges of the synchronised external clock.
- R6: In the external modes with the select bit set, external edges do not count. Only control writes with bit 0 set increment the counter, while the register still shifts on its external edge.
- R7: In the external modes, the serial output changes only on the edge opposite the sampling edge (falling for select 10, rising for select 11). Between such edges it holds.
- R8: A control write with bit 0 set inverts the clock-pin output register, whatever the mode.
- R9: Control readback returns the select field in bits [3:2]; bits [1:0] always read as zero.
- R10: A counter wrap from 15 to 0 sets a sticky overflow flag. The flag-clear input clears it. If a wrap and a clear fall in the same cycle, the flag is set.
- R11: A parallel register write loads all 8 bits and takes priority over a shift. A counter write takes priority over an increment. Reset clears the register, counter, flag, clock-pin output, control and serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 4 | Control data: [3:2] select, [1] strobe/select, [0] toggle |
| ctrl_rdata_o | output | 4 | Control readback |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| sck_i | input | 1 | External serial clock, asynchronous |
| sck_o | output | 1 | Clock-pin output register |
| din_i | input | 1 | Serial data input |
| dout_o | output | 1 | Serial data output |
| sr_wr_i | input | 1 | Parallel load of shift register |
| sr_wdata_i | input | 8 | Parallel load data |
| sr_rdata_o | output | 8 | Shift register contents |
| cnt_wr_i | input | 1 | Counter load |
| cnt_wdata_i | input | 4 | Counter load value |
| cnt_o | output | 4 | Counter value |
| ovf_clr_i | input | 1 | Overflow flag clear |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A counter wrap and a flag clear can land in the same cycle. The bench provokes this by holding the flag-clear input high during the strobe write that takes the counter from 15 to 0, and it expects the flag to end up set. A parallel load can also coincide with a strobe, and a counter load can coincide with an increment. In both cases the bench expects the loaded value to win, while the other resource still takes its own clock.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [1:0] {
    SRC_NONE    = 2'b00,
    SRC_TMR     = 2'b01,
    SRC_EXT_POS = 2'b10,
    SRC_EXT_NEG = 2'b11
  } src_e;

  typedef struct packed {
    logic shift;
    logic count;
    logic latch;
  } clk_route_t;
endpackage

// File: rtl/ssu_edge_sync.sv
module ssu_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES sync flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/ssu_clk_route.sv
module ssu_clk_route
  import ssu_pkg::*;
(
  input  src_e       src_i,
  input  logic       csel_i,
  input  logic       strobe_i,
  input  logic       tick_i,
  input  logic       tmr_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output clk_route_t route_o
);
  always_comb begin
    route_o = '0;
    unique case (src_i)
      SRC_NONE: begin
        route_o.shift = strobe_i;
        route_o.count = strobe_i;
      end
      SRC_TMR: begin
        route_o.shift = tmr_i;
        route_o.count = tmr_i;
      end
      SRC_EXT_POS: begin
        route_o.shift = rise_i;
        route_o.latch = fall_i;
        route_o.count = csel_i ? tick_i : (rise_i | fall_i);
      end
      default: begin
        route_o.shift = fall_i;
        route_o.latch = rise_i;
        route_o.count = csel_i ? tick_i : (rise_i | fall_i);
      end
    endcase
  end
endmodule

// File: rtl/ssu_shift_reg.sv
module ssu_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_data_i,
  input  logic             shift_i,
  input  logic             din_i,
  input  logic             latch_i,
  input  logic             ext_i,
  output logic [WIDTH-1:0] q_o,
  output logic             dout_o
);
  logic [WIDTH-1:0] sr_q;
  logic             dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      dout_q <= 1'b0;
    end else begin
      if (load_i)       sr_q <= load_data_i;
      else if (shift_i) sr_q <= {sr_q[WIDTH-2:0], din_i};
      if (latch_i)      dout_q <= sr_q[WIDTH-1];
    end
  end

  assign q_o    = sr_q;
  assign dout_o = ext_i ? dout_q : sr_q[WIDTH-1];
endmodule

// File: rtl/ssu_xfer_cnt.sv
module ssu_xfer_cnt #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_data_i,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = inc_i & ~load_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (load_i)     cnt_q <= load_data_i;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
      // set wins over clear
      if (wrap)       ovf_q <= 1'b1;
      else if (clr_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/ssu_clk_sel.sv
module ssu_clk_sel
  import ssu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [3:0]        ctrl_wdata_i,
  output logic [3:0]        ctrl_rdata_o,
  input  logic              tmr_ovf_i,
  input  logic              sck_i,
  output logic              sck_o,
  input  logic              din_i,
  output logic              dout_o,
  input  logic              sr_wr_i,
  input  logic [DATA_W-1:0] sr_wdata_i,
  output logic [DATA_W-1:0] sr_rdata_o,
  input  logic              cnt_wr_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  input  logic              ovf_clr_i,
  output logic              ovf_o
);
  localparam int SEL_HI = 3;
  localparam int SEL_LO = 2;
  localparam int BIT_SC = 1;
  localparam int BIT_TG = 0;

  src_e       src_q, src_eff;
  logic       csel_q, csel_eff;
  logic       sck_q, din_q;
  logic       sw_strobe, sw_tick;
  logic       ext_rise, ext_fall;
  clk_route_t route;

  // a write applies its own selection in the same cycle
  always_comb begin
    src_eff   = ctrl_wr_i ? src_e'(ctrl_wdata_i[SEL_HI:SEL_LO]) : src_q;
    csel_eff  = ctrl_wr_i ? ctrl_wdata_i[BIT_SC] : csel_q;
    sw_strobe = ctrl_wr_i & ctrl_wdata_i[BIT_SC];
    sw_tick   = ctrl_wr_i & ctrl_wdata_i[BIT_TG];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= SRC_NONE;
      csel_q <= 1'b0;
      sck_q  <= 1'b0;
      din_q  <= 1'b0;
    end else begin
      if (ctrl_wr_i) begin
        src_q  <= src_e'(ctrl_wdata_i[SEL_HI:SEL_LO]);
        csel_q <= ctrl_wdata_i[BIT_SC];
      end
      if (sw_tick) sck_q <= ~sck_q;
      din_q <= din_i;
    end
  end

  ssu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sck_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  ssu_clk_route u_route (
    .src_i   (src_eff),
    .csel_i  (csel_eff),
    .strobe_i(sw_strobe),
    .tick_i  (sw_tick),
    .tmr_i   (tmr_ovf_i),
    .rise_i  (ext_rise),
    .fall_i  (ext_fall),
    .route_o (route)
  );

  ssu_shift_reg #(.WIDTH(DATA_W)) u_sr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sr_wr_i),
    .load_data_i(sr_wdata_i),
    .shift_i    (route.shift),
    .din_i      (din_q),
    .latch_i    (route.latch),
    .ext_i      (src_q[1]),
    .q_o        (sr_rdata_o),
    .dout_o     (dout_o)
  );

  ssu_xfer_cnt #(.WIDTH(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_wr_i),
    .load_data_i(cnt_wdata_i),
    .inc_i      (route.count),
    .clr_i      (ovf_clr_i),
    .cnt_o      (cnt_o),
    .ovf_o      (ovf_o)
  );

  assign ctrl_rdata_o = {src_q, 2'b00};
  assign sck_o        = sck_q;
endmodule

// File: rtl/ssu_clk_sel_chk.sv
module ssu_clk_sel_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_wr_i,
  input logic [3:0]        ctrl_wdata_i,
  input logic [3:0]        ctrl_rdata_o,
  input logic              tmr_ovf_i,
  input logic              sck_o,
  input logic              dout_o,
  input logic              sr_wr_i,
  input logic [DATA_W-1:0] sr_wdata_i,
  input logic [DATA_W-1:0] sr_rdata_o,
  input logic              cnt_wr_i,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              ovf_clr_i,
  input logic              ovf_o,
  input logic              din_q,
  input logic              ext_rise,
  input logic              ext_fall
);
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[3:2] == 2'b00 && !ctrl_wr_i && !sr_wr_i && !cnt_wr_i)
      |=> ($stable(sr_rdata_o) && $stable(cnt_o))); // R1

  AST_TMR_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[3:2] == 2'b01 && !ctrl_wr_i && !sr_wr_i && tmr_ovf_i)
      |=> (sr_rdata_o == {$past(sr_rdata_o[DATA_W-2:0]), $past(din_q)})); // R3

  AST_POS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[3:2] == 2'b10 && !ctrl_wr_i && !sr_wr_i && !ext_rise)
      |=> $stable(sr_rdata_o)); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[3:2] == 2'b10 && !ctrl_wr_i && !ext_fall)
      |=> $stable(dout_o)); // R7

  AST_PIN_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && ctrl_wdata_i[0]) |=> (sck_o != $past(sck_o))); // R8

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (cnt_o == '0)); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o); // R10

  AST_PAR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_i |=> (sr_rdata_o == $past(sr_wdata_i))); // R11
endmodule

bind ssu_clk_sel ssu_clk_sel_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_wr_i   (ctrl_wr_i),
  .ctrl_wdata_i(ctrl_wdata_i),
  .ctrl_rdata_o(ctrl_rdata_o),
  .tmr_ovf_i   (tmr_ovf_i),
  .sck_o       (sck_o),
  .dout_o      (dout_o),
  .sr_wr_i     (sr_wr_i),
  .sr_wdata_i  (sr_wdata_i),
  .sr_rdata_o  (sr_rdata_o),
  .cnt_wr_i    (cnt_wr_i),
  .cnt_o       (cnt_o),
  .ovf_clr_i   (ovf_clr_i),
  .ovf_o       (ovf_o),
  .din_q       (din_q),
  .ext_rise    (ext_rise),
  .ext_fall    (ext_fall)
);

// File: tb/ssu_clk_sel_tb.sv
module ssu_clk_sel_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_wr_i = 1'b0;
  logic [3:0] ctrl_wdata_i = '0;
  logic [3:0] ctrl_rdata_o;
  logic       tmr_ovf_i = 1'b0;
  logic       sck_i = 1'b0;
  logic       sck_o;
  logic       din_i = 1'b0;
  logic       dout_o;
  logic       sr_wr_i = 1'b0;
  logic [7:0] sr_wdata_i = '0;
  logic [7:0] sr_rdata_o;
  logic       cnt_wr_i = 1'b0;
  logic [3:0] cnt_wdata_i = '0;
  logic [3:0] cnt_o;
  logic       ovf_clr_i = 1'b0;
  logic       ovf_o;

  int n_cmp = 0;
  int n_err = 0;
  logic d0;

  always #2 clk_i = ~clk_i;

  ssu_clk_sel dut_i (.*);

  // {din, expected register, expected count} per strobe, start 0xA5 / 0
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 8'h4B, 4'd1}, {1'b0, 8'h96, 4'd2}, {1'b1, 8'h2D, 4'd3},
    {1'b1, 8'h5B, 4'd4}, {1'b0, 8'hB6, 4'd5}, {1'b0, 8'h6C, 4'd6},
    {1'b1, 8'hD9, 4'd7}, {1'b0, 8'hB2, 4'd8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = v;
    tick();
    ctrl_wr_i = 1'b0; ctrl_wdata_i = '0;
  endtask

  task automatic load_sr(input logic [7:0] v);
    sr_wr_i = 1'b1; sr_wdata_i = v;
    tick();
    sr_wr_i = 1'b0;
  endtask

  task automatic load_cnt(input logic [3:0] v);
    cnt_wr_i = 1'b1; cnt_wdata_i = v;
    tick();
    cnt_wr_i = 1'b0;
  endtask

  task automatic sck_to(input logic v);
    sck_i = v;
    repeat (3) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // reset state, R11
    chk("R11 reset sr", sr_rdata_o, 8'h00);
    chk("R11 reset cnt", cnt_o, 4'h0);
    chk("R11 reset ovf", ovf_o, 1'b0);
    chk("R11 reset sck_o", sck_o, 1'b0);
    chk("R11 reset dout", dout_o, 1'b0);
    chk("R9 reset ctrl", ctrl_rdata_o, 4'h0);
    rst_ni = 1'b1;
    tick();

    // R2 table walk: strobe shifts in value from the prior cycle
    wr_ctrl(4'b0000);
    load_sr(8'hA5);
    load_cnt(4'd0);
    for (int i = 0; i < 8; i++) begin
      din_i = VEC[i][12];
      tick();
      din_i = ~VEC[i][12];
      wr_ctrl(4'b0010);
      chk("R2 strobe sr", sr_rdata_o, VEC[i][11:4]);
      chk("R2 strobe cnt", cnt_o, VEC[i][3:0]);
      chk("R2 dout same cycle", dout_o, VEC[i][11]);
    end
    chk("R9 strobe reads zero", ctrl_rdata_o, 4'b0000);

    // R1 no clock: timer and external edges ignored
    load_sr(8'h3C);
    load_cnt(4'd5);
    tmr_ovf_i = 1'b1; tick(); tmr_ovf_i = 1'b0;
    sck_to(1'b1);
    sck_to(1'b0);
    chk("R1 idle sr", sr_rdata_o, 8'h3C);
    chk("R1 idle cnt", cnt_o, 4'd5);

    // R3 timer mode
    wr_ctrl(4'b0100);
    din_i = 1'b1; tick();
    tmr_ovf_i = 1'b1; tick(); tmr_ovf_i = 1'b0;
    chk("R3 tmr sr", sr_rdata_o, 8'h79);
    chk("R3 tmr cnt", cnt_o, 4'd6);
    wr_ctrl(4'b0110);
    chk("R3 strobe ignored sr", sr_rdata_o, 8'h79);
    chk("R3 strobe ignored cnt", cnt_o, 4'd6);
    chk("R9 select readback", ctrl_rdata_o, 4'b0100);

    // R4 R5 R7 external rising sample
    wr_ctrl(4'b1000);
    load_sr(8'hC0);
    load_cnt(4'd0);
    din_i = 1'b1; tick();
    d0 = dout_o;
    sck_to(1'b1);
    chk("R4 rise shift", sr_rdata_o, 8'h81);
    chk("R7 hold on sample edge", dout_o, d0);
    chk("R5 count rise", cnt_o, 4'd1);
    sck_to(1'b0);
    chk("R4 no shift on fall", sr_rdata_o, 8'h81);
    chk("R7 latch on fall", dout_o, 1'b1);
    chk("R5 count fall", cnt_o, 4'd2);
    din_i = 1'b0;
    sck_to(1'b1);
    chk("R4 rise shift 2", sr_rdata_o, 8'h02);
    chk("R7 hold 2", dout_o, 1'b1);
    sck_to(1'b0);
    chk("R7 latch on fall 2", dout_o, 1'b0);
    chk("R5 count 4", cnt_o, 4'd4);

    // R4 R7 external falling sample
    wr_ctrl(4'b1100);
    load_sr(8'h40);
    din_i = 1'b1; tick();
    sck_to(1'b1);
    chk("R4 no shift on rise", sr_rdata_o, 8'h40);
    chk("R7 latch on rise", dout_o, 1'b0);
    sck_to(1'b0);
    chk("R4 fall shift", sr_rdata_o, 8'h81);
    chk("R7 hold on fall", dout_o, 1'b0);
    sck_to(1'b1);
    chk("R7 latch on rise 2", dout_o, 1'b1);
    chk("R5 count both edges", cnt_o, 4'd7);

    // R6 counter from toggle writes only
    wr_ctrl(4'b1110);
    sck_to(1'b0);
    chk("R6 shift still on edge", sr_rdata_o, 8'h03);
    chk("R6 edge not counted", cnt_o, 4'd7);
    wr_ctrl(4'b1111);
    chk("R6 toggle counts", cnt_o, 4'd8);
    chk("R8 toggle sck_o", sck_o, 1'b1);
    chk("R9 bits low read zero", ctrl_rdata_o, 4'b1100);

    // R8 toggle in no-clock mode
    wr_ctrl(4'b0001);
    chk("R8 toggle back", sck_o, 1'b0);
    chk("R8 no count", cnt_o, 4'd8);
    chk("R8 no shift", sr_rdata_o, 8'h03);

    // R10 wrap flag, clear, collision
    load_cnt(4'd15);
    wr_ctrl(4'b0010);
    chk("R10 wrap cnt", cnt_o, 4'd0);
    chk("R10 flag set", ovf_o, 1'b1);
    repeat (3) tick();
    chk("R10 sticky", ovf_o, 1'b1);
    ovf_clr_i = 1'b1; tick(); ovf_clr_i = 1'b0;
    chk("R10 cleared", ovf_o, 1'b0);
    load_cnt(4'd15);
    ovf_clr_i = 1'b1;
    wr_ctrl(4'b0010);
    ovf_clr_i = 1'b0;
    chk("R10 set beats clear", ovf_o, 1'b1);

    // R11 load priority
    sr_wr_i = 1'b1; sr_wdata_i = 8'h5A;
    wr_ctrl(4'b0010);
    sr_wr_i = 1'b0;
    chk("R11 load beats shift", sr_rdata_o, 8'h5A);
    chk("R11 cnt still counts", cnt_o, 4'd1);
    chk("R11 msb out", dout_o, 1'b0);
    cnt_wr_i = 1'b1; cnt_wdata_i = 4'd9;
    wr_ctrl(4'b0010);
    cnt_wr_i = 1'b0;
    chk("R11 cnt load beats inc", cnt_o, 4'd9);

    summary();
  end
endmodule